// File: doc/BRIEF.md
# Serial configuration chain access port

This block gives software access to a long serial chain of write-once configuration flops through two narrow 64-bit registers. A data register moves a 6-bit chunk at a time. A write to it only stages the chunk. The staged bits enter the chain only once the processor signals that the writing instruction has retired. A cancel that arrives first discards them. A second, write-one control register shifts the next 6 chain bits out into the data register, where software can read them.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold the request stable. `req_ready` drops while the chain is stepping, and also while a staged chunk is waiting for retire or cancel. A read produces a one-cycle response pulse on the following cycle. The response cannot be back-pressured. The chain steps one bit per clock, least significant bit first. Every duplicate copy of the chain takes the same bit stream in lockstep.

Top module: `cfg_chain_port`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0, `req_ready` is 1, every chain bit is 0, and the data register reads 0.
- R2: `req_sel`=0 selects the data register and `req_sel`=1 selects the shift control register. A read of the data register returns its 6-bit field in bits [5:0] and zero in bits [63:6].
- R3: A write to the data register stages `req_wdata[5:0]` and leaves the chain unchanged until a retire arrives. The chain never changes while `busy` is low.
- R4: A `retire` pulse while a chunk is staged moves the 6 staged bits into the chain, least significant bit first. With a chain of N bits, the new image is {chunk, old[N-1:6]}.
- R5: Each transfer keeps `busy` high for exactly 6 cycles. `req_ready` is low while `busy` is high or a chunk is staged. A held request is accepted once both conditions clear.
- R6: Writing the control register with bit 0 = 1 moves the 6 chain bits at [5:0] into the data register, with bit 0 first. The chain rotates, giving {old[5:0], old[N-1:6]}.
- R7: Writing the control register with bit 0 = 0 starts no transfer and changes neither the chain nor the data register. A read of the control register returns 0.
- R8: `cancel` while a chunk is staged discards the chunk. If `cancel` and `retire` arrive together, `cancel` takes effect. A `retire` with no staged chunk has no effect.
- R9: Every duplicate copy of the chain holds the same image as the primary copy at all times.
- R10: After N/6 chunk writes, the image holds the first chunk at [5:0] and each later chunk 6 bits higher. N/6 shift-and-read steps then return the chunks in write order and restore the image.
- R11: An accepted read raises `rsp_valid` for exactly one cycle, on the next cycle, with `rsp_rdata` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = data register, 1 = shift control register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 64 | Read response data |
| retire | input | 1 | Staged write's instruction has retired |
| cancel | input | 1 | Staged write is flushed |
| busy | output | 1 | Chain transfer in progress |
| chain_image | output | CHAIN_LEN | Primary chain copy contents |
| chain_copy_image | output | CHAIN_LEN | Last duplicate chain copy contents |

## Verification
The assertions check these properties on every cycle:
- the reserved read bits stay zero;
- the chain is frozen whenever no transfer is running;
- each busy period lasts exactly six cycles;
- no request is accepted while busy;
- reads of the control register return zero;
- the duplicate copies match;
- every response pulse traces back to an accepted read.

Only the bench scenarios can show the rest. These cover the bit order and placement of chunks in the chain image, and the rotation on readback. They also cover retire and cancel ordering, the no-effect cases, and holding a request across a transfer. All 64 chunk values are swept through a 24-bit chain and read back.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
  localparam int unsigned DEF_CHUNK_W = 6;
  localparam int unsigned DEF_REG_W   = 64;

  typedef enum logic {
    SEL_DATA  = 1'b0,
    SEL_SHIFT = 1'b1
  } reg_sel_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } step_dir_e;
endpackage

// File: rtl/cfgc_decode.sv
module cfgc_decode
  import cfgc_pkg::*;
#(
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned CHUNK_W = DEF_CHUNK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_sel,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic               can_accept,
  input  logic [CHUNK_W-1:0] data_val,
  output logic               stage_wr,
  output logic [CHUNK_W-1:0] stage_bits,
  output logic               shift_go,
  output logic               rsp_valid,
  output logic [REG_W-1:0]   rsp_rdata
);
  localparam int unsigned PAD_W = REG_W - CHUNK_W;

  logic accept;
  logic rd_en;
  logic is_data;

  assign accept     = req_valid & can_accept;
  assign is_data    = (req_sel == SEL_DATA);
  assign stage_wr   = accept & req_write & is_data;
  assign shift_go   = accept & req_write & ~is_data & req_wdata[0];
  assign rd_en      = accept & ~req_write;
  assign stage_bits = req_wdata[CHUNK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        rsp_rdata <= is_data ? {{PAD_W{1'b0}}, data_val} : '0;
      end
    end
  end
endmodule

// File: rtl/cfgc_shifter.sv
module cfgc_shifter
  import cfgc_pkg::*;
#(
  parameter int unsigned CHUNK_W = DEF_CHUNK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stage_wr,
  input  logic [CHUNK_W-1:0] stage_bits,
  input  logic               shift_go,
  input  logic               retire,
  input  logic               cancel,
  input  logic               chain_lsb,
  output logic               busy,
  output logic               pending,
  output logic               step_en,
  output step_dir_e          step_dir,
  output logic               ser_bit,
  output logic [CHUNK_W-1:0] data_val
);
  localparam int unsigned CNT_W = (CHUNK_W > 1) ? $clog2(CHUNK_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHUNK_W - 1);

  logic [CHUNK_W-1:0] stage_q;
  logic [CHUNK_W-1:0] data_q;
  logic               pending_q;
  logic               busy_q;
  step_dir_e          dir_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= '0;
      data_q    <= '0;
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
      dir_q     <= DIR_IN;
      cnt_q     <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
      end
      if (dir_q == DIR_IN) begin
        stage_q <= stage_q >> 1;
      end else begin
        data_q <= {chain_lsb, data_q[CHUNK_W-1:1]};
      end
    end else if (stage_wr) begin
      stage_q   <= stage_bits;
      pending_q <= 1'b1;
    end else if (pending_q && cancel) begin
      pending_q <= 1'b0;
    end else if (pending_q && retire) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b1;
      dir_q     <= DIR_IN;
      cnt_q     <= '0;
    end else if (shift_go) begin
      busy_q <= 1'b1;
      dir_q  <= DIR_OUT;
      cnt_q  <= '0;
    end
  end

  assign busy     = busy_q;
  assign pending  = pending_q;
  assign step_en  = busy_q;
  assign step_dir = dir_q;
  assign ser_bit  = stage_q[0];
  assign data_val = data_q;
endmodule

// File: rtl/cfgc_chain.sv
module cfgc_chain
  import cfgc_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 24,
  parameter int unsigned COPIES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  step_dir_e            step_dir,
  input  logic                 ser_bit,
  output logic                 chain_lsb,
  output logic [CHAIN_LEN-1:0] primary_img,
  output logic [CHAIN_LEN-1:0] last_copy_img
);
  logic [COPIES-1:0][CHAIN_LEN-1:0] img_q;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    logic entry_bit;
    assign entry_bit = (step_dir == DIR_OUT) ? img_q[g][0] : ser_bit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        img_q[g] <= '0;
      end else if (step_en) begin
        img_q[g] <= {entry_bit, img_q[g][CHAIN_LEN-1:1]};
      end
    end
  end

  assign chain_lsb     = img_q[0][0];
  assign primary_img   = img_q[0];
  assign last_copy_img = img_q[COPIES-1];
endmodule

// File: rtl/cfg_chain_port.sv
module cfg_chain_port
  import cfgc_pkg::*;
#(
  parameter int unsigned REG_W     = DEF_REG_W,
  parameter int unsigned CHUNK_W   = DEF_CHUNK_W,
  parameter int unsigned CHAIN_LEN = 24,
  parameter int unsigned COPIES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_sel,
  input  logic [REG_W-1:0]     req_wdata,
  output logic                 rsp_valid,
  output logic [REG_W-1:0]     rsp_rdata,
  input  logic                 retire,
  input  logic                 cancel,
  output logic                 busy,
  output logic [CHAIN_LEN-1:0] chain_image,
  output logic [CHAIN_LEN-1:0] chain_copy_image
);
  logic               stage_wr;
  logic [CHUNK_W-1:0] stage_bits;
  logic               shift_go;
  logic               pending;
  logic               step_en;
  step_dir_e          step_dir;
  logic               ser_bit;
  logic               chain_lsb;
  logic [CHUNK_W-1:0] data_val;

  assign req_ready = ~busy & ~pending;

  cfgc_decode #(.REG_W(REG_W), .CHUNK_W(CHUNK_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_sel    (req_sel),
    .req_wdata  (req_wdata),
    .can_accept (req_ready),
    .data_val   (data_val),
    .stage_wr   (stage_wr),
    .stage_bits (stage_bits),
    .shift_go   (shift_go),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  cfgc_shifter #(.CHUNK_W(CHUNK_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_wr   (stage_wr),
    .stage_bits (stage_bits),
    .shift_go   (shift_go),
    .retire     (retire),
    .cancel     (cancel),
    .chain_lsb  (chain_lsb),
    .busy       (busy),
    .pending    (pending),
    .step_en    (step_en),
    .step_dir   (step_dir),
    .ser_bit    (ser_bit),
    .data_val   (data_val)
  );

  cfgc_chain #(.CHAIN_LEN(CHAIN_LEN), .COPIES(COPIES)) u_chain (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (step_en),
    .step_dir      (step_dir),
    .ser_bit       (ser_bit),
    .chain_lsb     (chain_lsb),
    .primary_img   (chain_image),
    .last_copy_img (chain_copy_image)
  );
endmodule

// File: rtl/cfgc_checker.sv
module cfgc_checker #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned CHUNK_W   = 6,
  parameter int unsigned CHAIN_LEN = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic                 req_sel,
  input logic                 rsp_valid,
  input logic [REG_W-1:0]     rsp_rdata,
  input logic                 busy,
  input logic [CHAIN_LEN-1:0] chain_image,
  input logic [CHAIN_LEN-1:0] chain_copy_image
);
  logic [7:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (busy) begin
      busy_run <= busy_run + 8'd1;
    end else begin
      busy_run <= '0;
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[REG_W-1:CHUNK_W] == '0));

  p_chain_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(chain_image));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 8'(CHUNK_W)));

  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_ctrl_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_sel)) |-> (rsp_rdata == '0));

  p_copies_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_image == chain_copy_image);

  p_rsp_traced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
endmodule

bind cfg_chain_port cfgc_checker #(
  .REG_W(REG_W), .CHUNK_W(CHUNK_W), .CHAIN_LEN(CHAIN_LEN)
) u_cfgc_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_write        (req_write),
  .req_sel          (req_sel),
  .rsp_valid        (rsp_valid),
  .rsp_rdata        (rsp_rdata),
  .busy             (busy),
  .chain_image      (chain_image),
  .chain_copy_image (chain_copy_image)
);

// File: tb/test_cfg_chain_port.sv
module test_cfg_chain_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int CHUNKS = N / 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_sel = 1'b0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic          retire = 1'b0;
  logic          cancel = 1'b0;
  logic          busy;
  logic [N-1:0]  chain_image;
  logic [N-1:0]  chain_copy_image;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [N-1:0] model = '0;
  logic [5:0]   dreg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_chain_port #(.CHAIN_LEN(N)) i_cfg_chain_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .retire(retire),
    .cancel(cancel), .busy(busy), .chain_image(chain_image),
    .chain_copy_image(chain_copy_image)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic sel, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_busy(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse(input bit do_ret, input bit do_can);
    @(negedge clk);
    retire = do_ret; cancel = do_can;
    @(posedge clk); #1;
    retire = 1'b0; cancel = 1'b0;
  endtask

  task automatic read_data(output logic [63:0] val);
    bus(1'b0, 1'b0, '0);
    val = rsp_rdata;
    check(rsp_valid === 1'b1, "R11 rsp_valid after read", rsp_valid, 1);
    check(val[63:6] === '0, "R2 reserved bits zero", val, {58'd0, val[5:0]});
    @(posedge clk); #1;
    check(rsp_valid === 1'b0, "R11 single response pulse", rsp_valid, 0);
  endtask

  task automatic write_chunk(input logic [63:0] wd, output int cyc);
    bus(1'b1, 1'b0, wd);
    pulse(1'b1, 1'b0);
    wait_busy(cyc);
    model = {wd[5:0], model[N-1:6]};
  endtask

  task automatic shift_out(output int cyc);
    bus(1'b1, 1'b1, 64'h1);
    wait_busy(cyc);
    dreg  = model[5:0];
    model = {model[5:0], model[N-1:6]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [N-1:0] img;
    int cyc;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check(busy === 1'b0, "R1 busy after reset", busy, 0);
    check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid === 1'b0, "R1 no response after reset", rsp_valid, 0);
    check(chain_image === '0, "R1 chain clear", chain_image, 0);
    read_data(rd);
    check(rd === 64'd0, "R1 data register zero", rd, 0);

    // R3 staging without chain change, R5 ready low while staged
    bus(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFEA);
    check(req_ready === 1'b0, "R5 ready low while staged", req_ready, 0);
    repeat (3) @(posedge clk); #1;
    check(chain_image === '0, "R3 chain untouched before retire", chain_image, 0);
    pulse(1'b1, 1'b0);
    wait_busy(cyc);
    model = {6'h2A, model[N-1:6]};
    check(cyc == 6, "R5 busy length shift-in", cyc, 6);
    check(chain_image === model, "R4 chunk enters on retire", chain_image, model);
    check(req_ready === 1'b1, "R5 ready after transfer", req_ready, 1);

    // R4 sweep of every chunk value, R9 copies
    for (int v = 0; v < 64; v++) begin
      write_chunk({58'h3FF_FFFF_FFFF_FFFF ^ 58'(v), 6'(v)}, cyc);
      check(chain_image === model, "R4 chain image after write", chain_image, model);
      check(chain_copy_image === chain_image, "R9 copy matches", chain_copy_image, chain_image);
    end

    // R10 image layout after last CHUNKS writes (60..63)
    img = '0;
    for (int k = 0; k < CHUNKS; k++) img[k*6 +: 6] = 6'(64 - CHUNKS + k);
    check(chain_image === img, "R10 chunk placement", chain_image, img);

    // R6/R10 readback in write order, chain restored
    for (int k = 0; k < CHUNKS; k++) begin
      shift_out(cyc);
      check(cyc == 6, "R5 busy length shift-out", cyc, 6);
      check(chain_image === model, "R6 chain rotates", chain_image, model);
      read_data(rd);
      check(rd[5:0] === 6'(64 - CHUNKS + k), "R10 readback order", rd, 64 - CHUNKS + k);
    end
    check(chain_image === img, "R10 chain restored", chain_image, img);

    // R7 write of 0 to control bit, control reads zero
    bus(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
    check(busy === 1'b0, "R7 no transfer on zero", busy, 0);
    @(posedge clk); #1;
    check(chain_image === img, "R7 chain unchanged", chain_image, img);
    read_data(rd);
    check(rd === {58'd0, dreg}, "R7 data register unchanged", rd, {58'd0, dreg});
    bus(1'b0, 1'b1, '0);
    check(rsp_rdata === 64'd0, "R7 control reads zero", rsp_rdata, 0);

    // R8 cancel, cancel beats retire, orphan retire
    bus(1'b1, 1'b0, 64'h15);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    check(busy === 1'b0, "R8 cancelled write not shifted", busy, 0);
    check(chain_image === img, "R8 chain after cancel", chain_image, img);
    bus(1'b1, 1'b0, 64'h2C);
    pulse(1'b1, 1'b1);
    @(posedge clk); #1;
    check(chain_image === img, "R8 cancel wins over retire", chain_image, img);
    check(req_ready === 1'b1, "R8 ready after cancel", req_ready, 1);
    pulse(1'b1, 1'b0);
    check(busy === 1'b0, "R8 orphan retire ignored", busy, 0);

    // R5 request held across a transfer
    bus(1'b1, 1'b0, 64'h33);
    fork
      bus(1'b1, 1'b1, 64'h1);
      pulse(1'b1, 1'b0);
    join
    model = {6'h33, model[N-1:6]};
    wait_busy(cyc);
    dreg  = model[5:0];
    model = {model[5:0], model[N-1:6]};
    check(chain_image === model, "R5 held shift after write", chain_image, model);
    read_data(rd);
    check(rd[5:0] === dreg, "R5 held shift data", rd, dreg);
    check(chain_copy_image === chain_image, "R9 copy after mixed ops", chain_copy_image, chain_image);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule